// File: doc/BRIEF.md
# Oversampled serial receiver with three-sample voting

This block receives asynchronous serial characters. Each character is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. The block does not make its own timing. An external divider gives it a one-cycle enable `tick16` sixteen times per bit period. The line input is re-timed by two flops. The receiver then takes three samples, at ticks 7, 8 and 9 of every bit period, and decides each bit by majority.

A finished character is written into a one-entry holding register and `ready` is raised. A one-cycle `rd` strobe empties the holding register. When a character completes, the block gives one-cycle pulses for noise, framing error, parity error and overrun. It also gives a pulse when a start bit is confirmed. The level outputs `idle` and `brk` show reception in progress and a held-low line. These outputs are meant to feed a status register outside this block.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset, `idle`=1, `ready`=0, `brk`=0, and no pulse output is high.
- R2: A character is received as start bit, then data bits 0..7 least significant bit first, then the optional parity bit, then the stop bit. When it completes, `data` holds the byte and `ready` goes to 1.
- R3: Each bit value is the majority of the samples taken at ticks 7, 8 and 9 of its bit period. Tick 0 is the first tick on which the re-timed line is seen low after having been high. A single deviating sample does not change the value. Two deviating samples do change it.
- R4: `noise_pulse` is high for one cycle at the completion of a character if any of its bits had samples that did not all agree.
- R5: `start_pulse` is high for one cycle when the vote of the start bit is low. If that vote is high, the start is rejected: no character is received, no pulse is raised, and the block returns to idle.
- R6: `frame_err_pulse` is high for one cycle at completion when the stop bit vote is low.
- R7: `par_mode` selects the parity: 2'b00 none (the stop bit follows data bit 7), 2'b01 even, 2'b10 odd, 2'b11 none.
- R8: `parity_err_pulse` is high for one cycle at completion when the parity bit disagrees with the selected parity. Even parity means the data bits plus the parity bit hold an even number of ones; odd parity means they hold an odd number.
- R9: If a character completes while `ready`=1 and `rd` is low, `overrun_pulse` is high for one cycle, the new byte is discarded, and `data` keeps the old byte.
- R10: A cycle with `rd`=1 clears `ready` on the next clock edge, unless a character completes in that same cycle.
- R11: `idle` is 0 from start detection until the character completes or the start is rejected, and 1 otherwise.
- R12: `brk` goes to 1 on the 256th consecutive tick on which the re-timed line is low, which is 16 bit times. It returns to 0 once the re-timed line is high. The character in progress during a break reports a framing error. No new start is detected until the line has gone high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line |
| par_mode | input | 2 | Parity selection (see R7) |
| rd | input | 1 | Read strobe that empties the holding register |
| data | output | 8 | Holding register contents |
| ready | output | 1 | Holding register holds an unread byte |
| idle | output | 1 | No character in progress |
| brk | output | 1 | Line held low for 16 bit times |
| start_pulse | output | 1 | Start bit confirmed |
| noise_pulse | output | 1 | Sample disagreement in the character |
| frame_err_pulse | output | 1 | Stop bit sampled low |
| parity_err_pulse | output | 1 | Parity mismatch |
| overrun_pulse | output | 1 | Character lost because the register was full |

## Verification
A level on `rxd` reaches the sampler two clocks later. The bench therefore changes `rxd` at the start of each four-clock tick slot and pulses `tick16` only in the slot's last clock. This way every tick sees its own slot's level, and slot 9 of the stop bit is the edge where `data`, `ready` and all completion pulses update.

Pulses are collected by a monitor on every edge. They are judged only after the stop bit and a few high slots have gone by, so no check depends on the exact edge.

`ready` is checked on the negedge after a read strobe. `brk` is checked at 250 and 260 low slots, on either side of the 256th tick, and then one slot after the line goes high.

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OSR      = 16,
  parameter int DW       = 8,
  parameter int BRK_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    par_mode,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          ready,
  output logic          idle,
  output logic          brk,
  output logic          start_pulse,
  output logic          noise_pulse,
  output logic          frame_err_pulse,
  output logic          parity_err_pulse,
  output logic          overrun_pulse
);
  localparam int CW        = $clog2(OSR);
  localparam int IW        = $clog2(DW);
  localparam int MID       = OSR / 2;
  localparam int BRK_TICKS = OSR * BRK_BITS;
  localparam int BW        = $clog2(BRK_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic          rx_m, rx_s, last_rx;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bit_idx;
  logic          s_a, s_b, par_bit, noise_acc;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bcnt;

  wire vote     = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  wire disagree = !((s_a == s_b) && (s_b == rx_s));
  wire at_vote  = tick16 && (cnt == CW'(MID + 1));
  wire at_end   = tick16 && (cnt == CW'(OSR - 1));
  wire par_on   = (par_mode == 2'b01) || (par_mode == 2'b10);
  wire odd_sel  = (par_mode == 2'b10);
  wire done     = at_vote && (st == S_STOP);

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; last_rx <= 1'b1;
      st <= S_IDLE; cnt <= '0; bit_idx <= '0;
      s_a <= 1'b1; s_b <= 1'b1; par_bit <= 1'b0; noise_acc <= 1'b0;
      shreg <= '0; data <= '0; ready <= 1'b0;
      start_pulse <= 1'b0; noise_pulse <= 1'b0; frame_err_pulse <= 1'b0;
      parity_err_pulse <= 1'b0; overrun_pulse <= 1'b0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      start_pulse <= 1'b0; noise_pulse <= 1'b0; frame_err_pulse <= 1'b0;
      parity_err_pulse <= 1'b0; overrun_pulse <= 1'b0;
      if (rd) ready <= 1'b0;
      if (tick16) last_rx <= rx_s;
      if (st == S_IDLE) begin
        if (tick16 && !rx_s && last_rx) begin
          st <= S_START;
          cnt <= CW'(1);
          noise_acc <= 1'b0;
        end
      end else begin
        if (tick16) cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
        if (tick16 && cnt == CW'(MID - 1)) s_a <= rx_s;
        if (tick16 && cnt == CW'(MID)) s_b <= rx_s;
        if (at_vote) noise_acc <= noise_acc | disagree;
        case (st)
          S_START: begin
            if (at_vote) begin
              if (vote) st <= S_IDLE;
              else start_pulse <= 1'b1;
            end
            if (at_end) begin
              st <= S_DATA;
              bit_idx <= '0;
            end
          end
          S_DATA: begin
            if (at_vote) shreg <= {vote, shreg[DW-1:1]};
            if (at_end) begin
              if (bit_idx == IW'(DW - 1)) st <= par_on ? S_PAR : S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          S_PAR: begin
            if (at_vote) par_bit <= vote;
            if (at_end) st <= S_STOP;
          end
          S_STOP: begin
            if (at_vote) begin
              st <= S_IDLE;
              frame_err_pulse <= !vote;
              noise_pulse <= noise_acc | disagree;
              parity_err_pulse <= par_on && ((^shreg ^ par_bit) != odd_sel);
              if (ready && !rd) overrun_pulse <= 1'b1;
              else begin
                data <= shreg;
                ready <= 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      brk <= 1'b0;
    end else if (rx_s) begin
      bcnt <= '0;
      brk <= 1'b0;
    end else if (tick16 && bcnt != BW'(BRK_TICKS)) begin
      bcnt <= bcnt + 1'b1;
      if (bcnt == BW'(BRK_TICKS - 1)) brk <= 1'b1;
    end
  end
endmodule

module uart_rx_vote_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd,
  input logic          ready,
  input logic          idle,
  input logic          brk,
  input logic          rx_s,
  input logic          done,
  input logic [DW-1:0] data,
  input logic          start_pulse,
  input logic          overrun_pulse,
  input logic          frame_err_pulse
);
  p_ready_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !ready);
  p_ready_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ready) |=> ready);
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_pulse |-> (ready && data == $past(data)));
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (!idle && !frame_err_pulse));
  p_brk_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_s |=> !brk);
endmodule

bind uart_rx_vote uart_rx_vote_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .ready(ready), .idle(idle), .brk(brk),
  .rx_s(rx_s), .done(done), .data(data), .start_pulse(start_pulse),
  .overrun_pulse(overrun_pulse), .frame_err_pulse(frame_err_pulse)
);

// File: tb/uart_rx_vote_test.sv
module uart_rx_vote_test;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] data;
  logic ready, idle, brk, start_pulse, noise_pulse, frame_err_pulse;
  logic parity_err_pulse, overrun_pulse;

  int checks = 0, errors = 0;
  int n_start, n_noise, n_fe, n_pe, n_ov, n_busy;
  logic mon_clr = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_vote uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .par_mode(par_mode),
    .rd(rd), .data(data), .ready(ready), .idle(idle), .brk(brk),
    .start_pulse(start_pulse), .noise_pulse(noise_pulse),
    .frame_err_pulse(frame_err_pulse), .parity_err_pulse(parity_err_pulse),
    .overrun_pulse(overrun_pulse)
  );

  always @(posedge clk) begin
    if (mon_clr) begin
      n_start <= 0; n_noise <= 0; n_fe <= 0; n_pe <= 0; n_ov <= 0; n_busy <= 0;
    end else begin
      n_start <= n_start + int'(start_pulse);
      n_noise <= n_noise + int'(noise_pulse);
      n_fe    <= n_fe + int'(frame_err_pulse);
      n_pe    <= n_pe + int'(parity_err_pulse);
      n_ov    <= n_ov + int'(overrun_pulse);
      n_busy  <= n_busy + int'(!idle);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic slot(input logic v);
    rxd = v; tick16 = 1'b0;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic slots(input logic v, input int n);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  task automatic read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] pm, input bit bad_par,
                       input logic stop_v, input int nbit, input int nmask);
    logic [10:0] bits;
    int nb;
    logic p;
    par_mode = pm;
    p = (pm == 2'b10) ? ~^d : ^d;
    if (bad_par) p = ~p;
    bits = '0;
    bits[8:1] = d;
    if (pm == 2'b01 || pm == 2'b10) begin
      bits[9] = p; bits[10] = stop_v; nb = 11;
    end else begin
      bits[9] = stop_v; nb = 10;
    end
    for (int b = 0; b < nb; b++)
      for (int s = 0; s < 16; s++) begin
        logic v;
        v = bits[b];
        if (b == nbit && ((s == 8 && nmask[0]) || (s == 7 && nmask[1]))) v = ~v;
        slot(v);
      end
    slots(1'b1, 4);
  endtask

  task automatic t_reset();
    check(idle === 1'b1, "R1 idle", int'(idle), 1);
    check(ready === 1'b0, "R1 ready", int'(ready), 0);
    check(brk === 1'b0, "R1 brk", int'(brk), 0);
    check(n_start + n_noise + n_fe + n_pe + n_ov == 0, "R1 pulses",
          n_start + n_noise + n_fe + n_pe + n_ov, 0);
  endtask

  task automatic t_basic();
    clr();
    frame(8'hA5, 2'b00, 0, 1'b1, -1, 0);
    check(data == 8'hA5, "R2 data", int'(data), 'hA5);
    check(ready === 1'b1, "R2 ready", int'(ready), 1);
    check(n_start == 1, "R5 start", n_start, 1);
    check(n_busy > 100, "R11 busy seen", n_busy, 101);
    check(idle === 1'b1, "R11 idle after", int'(idle), 1);
    check(n_fe + n_pe + n_noise + n_ov == 0, "R7 no errors with no parity",
          n_fe + n_pe + n_noise + n_ov, 0);
    read();
    check(ready === 1'b0, "R10 read clears", int'(ready), 0);
  endtask

  task automatic t_parity();
    clr();
    frame(8'h3C, 2'b01, 0, 1'b1, -1, 0);
    check(data == 8'h3C && n_pe == 0 && n_fe == 0, "R7 even ok", n_pe + n_fe, 0);
    read(); clr();
    frame(8'h3D, 2'b10, 0, 1'b1, -1, 0);
    check(data == 8'h3D && n_pe == 0 && n_fe == 0, "R7 odd ok", n_pe + n_fe, 0);
    read(); clr();
    frame(8'h3C, 2'b01, 1, 1'b1, -1, 0);
    check(n_pe == 1, "R8 even mismatch", n_pe, 1);
    read(); clr();
    frame(8'h01, 2'b10, 1, 1'b1, -1, 0);
    check(n_pe == 1, "R8 odd mismatch", n_pe, 1);
    read(); clr();
    frame(8'h55, 2'b11, 0, 1'b1, -1, 0);
    check(data == 8'h55 && n_pe == 0 && n_fe == 0, "R7 mode 3 as none", int'(data), 'h55);
    read();
  endtask

  task automatic t_noise();
    clr();
    frame(8'h00, 2'b00, 0, 1'b1, 4, 1);
    check(data == 8'h00, "R3 single sample outvoted", int'(data), 0);
    check(n_noise == 1, "R4 noise one sample", n_noise, 1);
    read(); clr();
    frame(8'h00, 2'b00, 0, 1'b1, 4, 3);
    check(data == 8'h08, "R3 two samples win", int'(data), 8);
    check(n_noise == 1, "R4 noise two samples", n_noise, 1);
    read(); clr();
    frame(8'h96, 2'b00, 0, 1'b1, -1, 0);
    check(n_noise == 0, "R4 clean char", n_noise, 0);
    read();
  endtask

  task automatic t_frame();
    clr();
    frame(8'h5A, 2'b00, 0, 1'b0, -1, 0);
    check(n_fe == 1, "R6 stop low", n_fe, 1);
    read();
  endtask

  task automatic t_overrun();
    clr();
    frame(8'h11, 2'b00, 0, 1'b1, -1, 0);
    frame(8'h22, 2'b00, 0, 1'b1, -1, 0);
    check(n_ov == 1, "R9 overrun pulse", n_ov, 1);
    check(data == 8'h11 && ready === 1'b1, "R9 old byte kept", int'(data), 'h11);
    read();
  endtask

  task automatic t_glitch();
    clr();
    slots(1'b0, 3);
    slots(1'b1, 20);
    check(n_start == 0, "R5 glitch no start", n_start, 0);
    check(ready === 1'b0 && idle === 1'b1, "R5 glitch no char", int'(ready), 0);
  endtask

  task automatic t_break();
    par_mode = 2'b00;
    clr();
    slots(1'b0, 250);
    check(brk === 1'b0, "R12 before 256 ticks", int'(brk), 0);
    slots(1'b0, 10);
    check(brk === 1'b1, "R12 after 256 ticks", int'(brk), 1);
    check(n_fe == 1 && n_start == 1, "R12 framing error once", n_fe, 1);
    check(data == 8'h00 && ready === 1'b1, "R12 break char", int'(data), 0);
    slot(1'b1);
    check(brk === 1'b0, "R12 clears on high", int'(brk), 0);
    read();
    slots(1'b1, 4);
  endtask

  initial begin
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_clr = 1'b0;
    @(negedge clk);
    t_reset();
    slots(1'b1, 4);
    t_basic();
    t_parity();
    t_noise();
    t_frame();
    t_overrun();
    t_glitch();
    t_break();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule